// File: doc/BRIEF.md
# Burst Column Address Generator

This block supplies the column address for every beat of a memory burst. A load pulse captures a start column together with a burst length code and a burst order. From the next cycle on, the block presents the address of the current beat and advances by one beat on every cycle in which the step enable is high. It raises a last-beat flag on the final address of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats vary only the low column bits that the length selects. The remaining upper bits stay fixed for the whole burst. In sequential order the low bits count upward and wrap with no carry into the upper bits. In interleave order the start column is XORed with the beat index. A full-page burst walks the whole row, wraps from the top column to column 0, and keeps running until a stop request or a new load ends it. A load during a burst drops the rest of that burst and starts a new burst of the full programmed length. Holding the step enable low freezes the sequence, which models a suspended clock.

Top module: `col_burst_agen`

## Requirements
- R1: While reset is asserted and after it is released with no load, `busy_o` and `last_o` are 0 and `col_o` is 0.
- R2: One cycle after `load_i` is sampled high, `busy_o` is 1 and `col_o` equals the sampled `start_col_i`. This holds whatever the values of `step_en_i` and `stop_i`.
- R3: Sequential order (`ilv_i`=0) uses length codes 1, 2 and 3 for 2, 4 and 8 beats. Beat k presents the start column with its low 1, 2 or 3 bits replaced by the low bits of (start + k). There is no carry into the upper bits.
- R4: Interleave order (`ilv_i`=1) presents start XOR k on beat k. For fixed lengths, k stays below the burst length.
- R5: Length code 7 selects a full-page burst. It presents (start + k) mod 256 in sequential order and start XOR (k mod 256) in interleave order, and it continues without end until it is stopped or reloaded.
- R6: `last_o` is 1 exactly while a fixed-length burst shows its final beat, and it is never 1 in a full-page burst. Length code 0 gives a 1-beat burst, with `last_o` high on its only beat. Once the final beat is stepped, `busy_o` drops to 0.
- R7: While `step_en_i` is 0 and neither a load nor an honoured stop is sampled, `col_o`, `busy_o` and `last_o` hold their values.
- R8: A load sampled during a burst takes priority over stepping and stopping. It restarts at the new column with the new mode and the full burst length.
- R9: `stop_i` sampled during a full-page burst ends it on the next cycle, whatever `step_en_i` is. During a fixed-length burst `stop_i` has no effect.
- R10: Length codes 4, 5 and 6 behave as code 0, giving a 1-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a new burst from the inputs below |
| start_col_i | input | 8 | Start column |
| len_code_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| ilv_i | input | 1 | 0 sequential order, 1 interleave order |
| step_en_i | input | 1 | Advance one beat this cycle |
| stop_i | input | 1 | End a full-page burst |
| col_o | output | 8 | Column of the current beat, 0 when idle |
| busy_o | output | 1 | A burst is in progress and `col_o` is valid |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The assertions assume that `load_i`, `step_en_i` and `stop_i` are driven to known levels on every clock edge after reset. They also assume that the mode inputs are sampled only together with a load, so that the captured mode stays constant inside a burst. The stimulus changes inputs only at the falling edge and draws load, stop and enable from $urandom with set probabilities. It mixes all length codes, including the reserved ones, with both orders and random start columns. Directed sequences cover the boundaries: wrapping of the low bits, wrapping of the whole row, one-beat bursts, and stop or reload against each burst kind.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

   typedef enum logic [2:0] {
      BLEN_ONE   = 3'd0,
      BLEN_TWO   = 3'd1,
      BLEN_FOUR  = 3'd2,
      BLEN_EIGHT = 3'd3,
      BLEN_PAGE  = 3'd7
   } blen_e;

   localparam int unsigned LEN_CODE_W = 3;

endpackage

// File: rtl/col_burst_ctrl.sv
module col_burst_ctrl
   import col_burst_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             ilv_i,
   input  logic             step_en_i,
   input  logic             stop_i,
   output logic             busy_o,
   output logic             last_o,
   output logic             full_o,
   output logic             ilv_o,
   output logic [COL_W-1:0] mask_o,
   output logic [COL_W-1:0] start_o,
   output logic [COL_W-1:0] beat_o
);

   localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

   function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
      logic [COL_W-1:0] m;
      case (code)
         BLEN_TWO:   m = COL_W'(1);
         BLEN_FOUR:  m = COL_W'(3);
         BLEN_EIGHT: m = COL_W'(7);
         BLEN_PAGE:  m = ALL_ONES;
         default:    m = '0;
      endcase
      return m;
   endfunction

   logic             busy_q, full_q, ilv_q;
   logic [COL_W-1:0] mask_q, start_q, beat_q;
   logic             at_end;

   assign at_end = (beat_q == mask_q) && !full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         full_q  <= 1'b0;
         ilv_q   <= 1'b0;
         mask_q  <= '0;
         start_q <= '0;
         beat_q  <= '0;
      end else if (load_i) begin
         busy_q  <= 1'b1;
         full_q  <= (len_code_i == BLEN_PAGE);
         ilv_q   <= ilv_i;
         mask_q  <= len_mask(len_code_i);
         start_q <= start_col_i;
         beat_q  <= '0;
      end else if (busy_q) begin
         if (stop_i && full_q) begin
            busy_q <= 1'b0;
         end else if (step_en_i) begin
            if (at_end) busy_q <= 1'b0;
            else        beat_q <= beat_q + 1'b1;
         end
      end
   end

   assign busy_o  = busy_q;
   assign last_o  = busy_q && at_end;
   assign full_o  = full_q;
   assign ilv_o   = ilv_q;
   assign mask_o  = mask_q;
   assign start_o = start_q;
   assign beat_o  = beat_q;

   // R9: stop has no effect on a fixed burst that is not ending anyway
   p_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && stop_i && !full_q && !load_i && !last_o |=> busy_q);

   // R6: stepping the final beat ends the burst
   p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && step_en_i && !load_i |=> !busy_q);

endmodule

// File: rtl/col_burst_map.sv
module col_burst_map #(
   parameter int unsigned COL_W = 8
) (
   input  logic             busy_i,
   input  logic             ilv_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic [COL_W-1:0] start_i,
   input  logic [COL_W-1:0] beat_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] raw;

   assign sum = start_i + beat_i;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      logic seq_bit, ilv_bit;
      assign seq_bit = mask_i[i] ? sum[i] : start_i[i];
      assign ilv_bit = start_i[i] ^ (beat_i[i] & mask_i[i]);
      assign raw[i]  = ilv_i ? ilv_bit : seq_bit;
   end

   assign col_o = busy_i ? raw : '0;

endmodule

// File: rtl/col_burst_agen.sv
module col_burst_agen
   import col_burst_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             ilv_i,
   input  logic             step_en_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             busy_o,
   output logic             last_o
);

   if (COL_W < 3) begin : g_bad_width
      $error("col_burst_agen: COL_W must cover an 8-beat burst");
   end
   if (LEN_CODE_W != 3) begin : g_bad_code
      $error("col_burst_agen: length code width mismatch");
   end

   logic             busy, last, full, ilv;
   logic [COL_W-1:0] mask, start, beat;

   col_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .start_col_i(start_col_i),
      .len_code_i (len_code_i),
      .ilv_i      (ilv_i),
      .step_en_i  (step_en_i),
      .stop_i     (stop_i),
      .busy_o     (busy),
      .last_o     (last),
      .full_o     (full),
      .ilv_o      (ilv),
      .mask_o     (mask),
      .start_o    (start),
      .beat_o     (beat)
   );

   col_burst_map #(.COL_W(COL_W)) u_map (
      .busy_i (busy),
      .ilv_i  (ilv),
      .mask_i (mask),
      .start_i(start),
      .beat_i (beat),
      .col_o  (col_o)
   );

   assign busy_o = busy;
   assign last_o = last;

   // R2: a load shows its start column on the next cycle
   p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> busy_o && (col_o == $past(start_col_i)));

   // R3, R4: bits outside the burst field never change while stepping
   p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && step_en_i && !load_i && !stop_i && !last_o
      |=> (((col_o ^ $past(col_o)) & ~mask) == '0));

   // R6: no last-beat flag in a full-page burst
   p_no_last_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && full |-> !last_o);

   // R7: a disabled step freezes the address
   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !step_en_i && !load_i && !stop_i |=> $stable(col_o) && busy_o);

   // R9: stop ends a full-page burst
   p_page_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && full && stop_i && !load_i |=> !busy_o);

   // R1: idle output is zero
   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (col_o == '0) && !last_o);

endmodule

// File: tb/col_burst_agen_bench.sv
`timescale 1ns/1ps
module col_burst_agen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       ilv_i = 1'b0;
   logic       step_en_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       busy_o, last_o;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   // expected state
   bit       e_busy, e_full, e_ilv;
   bit [7:0] e_start, e_beat, e_mask;

   always #2.5 clk = ~clk;

   col_burst_agen u_col_burst_agen (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
      .len_code_i(len_code_i), .ilv_i(ilv_i), .step_en_i(step_en_i),
      .stop_i(stop_i), .col_o(col_o), .busy_o(busy_o), .last_o(last_o)
   );

   function automatic bit [7:0] code_mask(input bit [2:0] c);
      case (c)
         3'd1: return 8'h01;
         3'd2: return 8'h03;
         3'd3: return 8'h07;
         3'd7: return 8'hFF;
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit [7:0] exp_col();
      bit [7:0] s;
      if (!e_busy) return 8'h00;
      if (e_ilv) return e_start ^ (e_beat & e_mask);
      s = e_start + e_beat;
      return (e_start & ~e_mask) | (s & e_mask);
   endfunction

   function automatic bit exp_last();
      return e_busy && !e_full && (e_beat == e_mask);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "col_o", col_o, exp_col());
      check(tag, "busy_o", busy_o, e_busy);
      check(tag, "last_o", last_o, exp_last());
   endtask

   task automatic cyc(input bit ld, input bit [7:0] st, input bit [2:0] lc,
                      input bit il, input bit en, input bit sp, input string tag);
      @(negedge clk);
      load_i = ld; start_col_i = st; len_code_i = lc; ilv_i = il;
      step_en_i = en; stop_i = sp;
      @(posedge clk);
      if (ld) begin
         e_busy = 1; e_start = st; e_beat = 0; e_mask = code_mask(lc);
         e_full = (lc == 3'd7); e_ilv = il;
      end else if (e_busy) begin
         if (sp && e_full) e_busy = 0;
         else if (en) begin
            if (!e_full && e_beat == e_mask) e_busy = 0;
            else e_beat = e_beat + 8'd1;
         end
      end
      #1;
      check_all(tag);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED_0C01);
      e_busy = 0; e_full = 0; e_ilv = 0; e_start = 0; e_beat = 0; e_mask = 0;
      // R1: reset state
      repeat (2) @(posedge clk);
      #1;
      check_all("R1");
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 8'h00, 3'd0, 0, 1, 0, "R1");

      // R2: load with enable low still presents start
      cyc(1, 8'hA5, 3'd2, 0, 0, 1, "R2");
      check("R2", "col after load", col_o, 8'hA5);
      repeat (5) cyc(0, 0, 0, 0, 1, 0, "R2");

      // R3: sequential 8-beat wrap inside low three bits
      cyc(1, 8'h5E, 3'd3, 0, 1, 0, "R3");
      repeat (3) cyc(0, 0, 0, 0, 1, 0, "R3");
      check("R3", "wrapped col", col_o, 8'h59);
      repeat (6) cyc(0, 0, 0, 0, 1, 0, "R3");
      // sequential 2 and 4
      cyc(1, 8'h1F, 3'd1, 0, 1, 0, "R3");
      cyc(0, 0, 0, 0, 1, 0, "R3");
      check("R3", "bl2 wrap", col_o, 8'h1E);
      cyc(1, 8'hC6, 3'd2, 0, 1, 0, "R3");
      repeat (4) cyc(0, 0, 0, 0, 1, 0, "R3");

      // R4: interleave 8-beat
      cyc(1, 8'h5E, 3'd3, 1, 1, 0, "R4");
      repeat (2) cyc(0, 0, 0, 0, 1, 0, "R4");
      check("R4", "ilv beat2", col_o, 8'h5C);
      repeat (7) cyc(0, 0, 0, 0, 1, 0, "R4");

      // R5: full page crossing the row end, more than 256 beats
      cyc(1, 8'hFE, 3'd7, 0, 1, 0, "R5");
      repeat (2) cyc(0, 0, 0, 0, 1, 0, "R5");
      check("R5", "row wrap", col_o, 8'h00);
      repeat (300) cyc(0, 0, 0, 0, 1, 0, "R5");
      // R9: stop with enable low ends full page
      cyc(0, 0, 0, 0, 0, 1, "R9");
      check("R9", "busy after stop", busy_o, 0);

      // R6: one-beat burst
      cyc(1, 8'h33, 3'd0, 0, 1, 0, "R6");
      check("R6", "last on single beat", last_o, 1);
      cyc(0, 0, 0, 0, 1, 0, "R6");

      // R7: freeze with enable low
      cyc(1, 8'h40, 3'd2, 1, 1, 0, "R7");
      cyc(0, 0, 0, 0, 1, 0, "R7");
      repeat (3) cyc(0, 0, 0, 0, 0, 0, "R7");
      check("R7", "frozen col", col_o, 8'h41);
      repeat (3) cyc(0, 0, 0, 0, 1, 0, "R7");

      // R8: reload mid-burst gives full new length
      cyc(1, 8'h10, 3'd3, 0, 1, 0, "R8");
      repeat (3) cyc(0, 0, 0, 0, 1, 0, "R8");
      cyc(1, 8'h87, 3'd3, 0, 1, 1, "R8");
      check("R8", "reload col", col_o, 8'h87);
      repeat (8) cyc(0, 0, 0, 0, 1, 0, "R8");

      // R9: stop ignored on fixed burst
      cyc(1, 8'h20, 3'd2, 0, 1, 0, "R9");
      cyc(0, 0, 0, 0, 1, 1, "R9");
      check("R9", "busy kept", busy_o, 1);
      repeat (4) cyc(0, 0, 0, 0, 1, 1, "R9");

      // R10: reserved codes as one-beat bursts
      for (int c = 4; c < 7; c++) begin
         cyc(1, 8'h77, 3'(c), 0, 1, 0, "R10");
         check("R10", "last on reserved", last_o, 1);
         cyc(0, 0, 0, 0, 1, 0, "R10");
      end

      // random mix
      for (int i = 0; i < 6000; i++) begin
         bit ld, en, sp, il;
         bit [2:0] lc;
         bit [7:0] st;
         string tg;
         ld = ($urandom % 12) == 0;
         en = ($urandom % 4) != 0;
         sp = ($urandom % 20) == 0;
         il = $urandom % 2;
         lc = $urandom % 8;
         st = $urandom % 256;
         if (ld) tg = "R8";
         else if (!en) tg = "R7";
         else if (e_full) tg = "R5";
         else if (e_ilv) tg = "R4";
         else tg = "R3";
         cyc(ld, st, lc, il, en, sp, tg);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule